// File: doc/BRIEF.md
# Priority-Masked Interrupt Level Controller

This block takes sixteen interrupt request lines from on-chip and off-chip sources, plus one urgent line that skips all filtering. It turns them into a single encoded priority code for the processor. Each source is edge-signalled: the first cycle a line is seen high counts as one new interrupt. That event is recorded in an active-low pending register. The source's programmed 3-bit level is then compared with a threshold held in a mask register. Only a level strictly above the threshold lets the event reach the processor, as code 16 plus the source number. The urgent line always produces code 32. A line returning low produces code 0, which tells the processor that the request has cleared.

Software reaches the pending, threshold and per-source level settings through a small register window. A write carries 4-bit byte enables. Reads return one cycle later. Each source owns one byte lane of a level word, and only the three low bits of that lane take part in the comparison. A synchronous reset returns every register to its start value.

Source numbering: 0..6 are external lines 1..7, 7..10 are DMA channels 3, 2, 1, 0, 11..12 are serial ports 0 and 1, and 13..15 are timers 0, 1 and 2.

Top module: `irq_level_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the pending word becomes 0x0000FFFF, and the threshold and all level words become 0. `ip_code_o` becomes 0 and `ip_valid_o` becomes 0.
- R2: When `src_i[s]` rises, bit s of the pending word (offset 0) is cleared to 0. A line that stays high produces exactly one event.
- R3: The level of source s is bits [(s%4)*8+2 : (s%4)*8] of the level word at byte offset 16+4*(s/4). The other bits of that byte lane take no part in the comparison.
- R4: A rising source is reported only when its level is strictly greater than the full 32-bit threshold word at offset 4. Otherwise only its pending bit changes, and `ip_code_o` keeps its value.
- R5: A reported source event sets `ip_code_o` to 16+s with `ip_valid_o` high on the clock edge that samples the rise. `ip_valid_o` is high for one cycle only, and `ip_code_o` holds its value between events.
- R6: A rise on `bypass_i` gives code 32, whatever the pending bits, levels and threshold. It takes precedence over every source rising in the same cycle, and it changes no pending bit.
- R7: A fall on any source or on `bypass_i` gives code 0 with `ip_valid_o` high, unless a reportable rise happens in the same cycle.
- R8: When several sources rise together, all of their pending bits clear, and the lowest-numbered source that qualifies is reported.
- R9: A write replaces only the byte lanes whose enable bit is set (lane i = data bits [8i+7:8i]). Read data for the address given in one cycle appears on `bus_rdata_o` after the next clock edge.
- R10: Offsets 8 and 12 read as zero, and writes to them change no register.
- R11: Software may write the pending word to set bits back to 1. A source rise in the same cycle still clears its own bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | 16 | Interrupt source lines, index = source number |
| bypass_i | input | 1 | Urgent line, reported as code 32 |
| bus_addr_i | input | 5 | Byte address in the register window |
| bus_be_i | input | 4 | Byte-lane enables for a write |
| bus_wdata_i | input | 32 | Write data |
| bus_wr_i | input | 1 | Write strobe |
| bus_rdata_o | output | 32 | Registered read data |
| ip_code_o | output | 6 | Priority code: 0, 16..31 or 32 |
| ip_valid_o | output | 1 | One-cycle strobe per emitted code |

## Verification
The bench builds the block with its default sixteen sources and 3-bit levels. This size makes a full sweep of eight level patterns × eight thresholds × every source affordable, so each strict-greater-than outcome and each byte-lane placement of a level is compared with arithmetic in the bench. All sixteen byte-enable patterns are applied to a level word. Simultaneous rises, bypass precedence and a write that races a source edge are driven one at a time.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
    localparam int WORD_W = 32;
    localparam int CODE_W = 6;
    localparam int BE_W   = WORD_W / 8;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
    } ip_out_t;

    function automatic logic [WORD_W-1:0] lane_merge(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] new_w,
        input logic [BE_W-1:0]   be
    );
        logic [WORD_W-1:0] r;
        r = old_w;
        for (int i = 0; i < BE_W; i++) begin
            if (be[i]) r[i*8 +: 8] = new_w[i*8 +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_edge.sv
module irq_edge #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
        rise_o = sig_i & ~prev_q;
        fall_o = ~sig_i & prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= prev_d;
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NUM_SRC = 16,
    parameter int LVL_W   = 3,
    localparam int LVL_REGS = NUM_SRC / 4,
    localparam int IDX_W    = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]     rise_i,
    input  logic [31:0]            mask_i,
    input  logic [LVL_REGS*32-1:0] lvl_i,
    output logic                   hit_o,
    output logic [IDX_W-1:0]       idx_o
);
    logic [NUM_SRC-1:0] qual;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        logic [LVL_W-1:0] lvl;
        assign lvl     = lvl_i[(s/4)*32 + (s%4)*8 +: LVL_W];
        assign qual[s] = rise_i[s] && (32'(lvl) > mask_i);
    end

    always_comb begin
        hit_o = |qual;
        idx_o = '0;
        for (int s = NUM_SRC-1; s >= 0; s--) begin
            if (qual[s]) idx_o = IDX_W'(s);
        end
    end
endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
    import irq_lvl_pkg::*;
#(
    parameter int NUM_SRC = 16,
    localparam int LVL_REGS = NUM_SRC / 4,
    localparam int ADDR_W   = $clog2((4 + LVL_REGS) * 4),
    localparam int WIDX_W   = ADDR_W - 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [BE_W-1:0]        be_i,
    input  logic [WORD_W-1:0]      wdata_i,
    input  logic [NUM_SRC-1:0]     clr_i,
    output logic [WORD_W-1:0]      mask_o,
    output logic [LVL_REGS*32-1:0] lvl_o,
    output logic [WORD_W-1:0]      rdata_o
);
    typedef struct packed {
        logic [WORD_W-1:0]                  pend;
        logic [WORD_W-1:0]                  mask;
        logic [LVL_REGS-1:0][WORD_W-1:0]    lvl;
        logic [WORD_W-1:0]                  rdata;
    } bank_t;

    localparam logic [WORD_W-1:0] PEND_RST = WORD_W'({NUM_SRC{1'b1}});

    bank_t bank_d, bank_q;
    logic [WIDX_W-1:0] widx;

    always_comb begin
        bank_d = bank_q;
        widx   = addr_i[ADDR_W-1:2];

        bank_d.rdata = '0;
        if (int'(widx) == 0) bank_d.rdata = bank_q.pend;
        if (int'(widx) == 1) bank_d.rdata = bank_q.mask;
        for (int i = 0; i < LVL_REGS; i++) begin
            if (int'(widx) == 4 + i) bank_d.rdata = bank_q.lvl[i];
        end

        if (wr_i) begin
            if (int'(widx) == 0) bank_d.pend = lane_merge(bank_q.pend, wdata_i, be_i);
            if (int'(widx) == 1) bank_d.mask = lane_merge(bank_q.mask, wdata_i, be_i);
            for (int i = 0; i < LVL_REGS; i++) begin
                if (int'(widx) == 4 + i)
                    bank_d.lvl[i] = lane_merge(bank_q.lvl[i], wdata_i, be_i);
            end
        end

        bank_d.pend = bank_d.pend & ~WORD_W'(clr_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q      <= '0;
            bank_q.pend <= PEND_RST;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign mask_o  = bank_q.mask;
    assign lvl_o   = bank_q.lvl;
    assign rdata_o = bank_q.rdata;
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
    import irq_lvl_pkg::*;
#(
    parameter int NUM_SRC     = 16,
    parameter int LVL_W       = 3,
    parameter int BASE_CODE   = 16,
    parameter int BYPASS_CODE = 32,
    localparam int LVL_REGS = NUM_SRC / 4,
    localparam int ADDR_W   = $clog2((4 + LVL_REGS) * 4),
    localparam int IDX_W    = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bypass_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [BE_W-1:0]    bus_be_i,
    input  logic [WORD_W-1:0]  bus_wdata_i,
    input  logic               bus_wr_i,
    output logic [WORD_W-1:0]  bus_rdata_o,
    output logic [CODE_W-1:0]  ip_code_o,
    output logic               ip_valid_o
);
    logic [NUM_SRC:0]         rise, fall;
    logic [WORD_W-1:0]        mask;
    logic [LVL_REGS*32-1:0]   lvl;
    logic                     hit;
    logic [IDX_W-1:0]         idx;
    ip_out_t                  out_d, out_q;

    irq_edge #(.W(NUM_SRC + 1)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_i  ({bypass_i, src_i}),
        .rise_o (rise),
        .fall_o (fall)
    );

    irq_regbank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .be_i    (bus_be_i),
        .wdata_i (bus_wdata_i),
        .clr_i   (rise[NUM_SRC-1:0]),
        .mask_o  (mask),
        .lvl_o   (lvl),
        .rdata_o (bus_rdata_o)
    );

    irq_pick #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_pick (
        .rise_i (rise[NUM_SRC-1:0]),
        .mask_i (mask),
        .lvl_i  (lvl),
        .hit_o  (hit),
        .idx_o  (idx)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = 1'b0;
        if (rise[NUM_SRC]) begin
            out_d.valid = 1'b1;
            out_d.code  = CODE_W'(BYPASS_CODE);
        end else if (hit) begin
            out_d.valid = 1'b1;
            out_d.code  = CODE_W'(BASE_CODE) + CODE_W'(idx);
        end else if (|fall) begin
            out_d.valid = 1'b1;
            out_d.code  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign ip_code_o  = out_q.code;
    assign ip_valid_o = out_q.valid;
endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk #(
    parameter int NUM_SRC     = 16,
    parameter int BASE_CODE   = 16,
    parameter int BYPASS_CODE = 32
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] src_i,
    input logic               bypass_i,
    input logic [5:0]         ip_code_o,
    input logic               ip_valid_o
);
    logic [NUM_SRC:0] seen_q;
    logic             live_q;

    always_ff @(posedge clk) begin
        seen_q <= rst ? '0 : {bypass_i, src_i};
        live_q <= !rst;
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!ip_valid_o && ip_code_o == 6'd0));

    // R6
    a_r6_bypass_wins: assert property (@(posedge clk) disable iff (rst)
        (bypass_i && !seen_q[NUM_SRC]) |=> (ip_valid_o && ip_code_o == 6'(BYPASS_CODE)));

    // R5
    a_r5_code_range: assert property (@(posedge clk) disable iff (rst)
        ip_valid_o |-> (ip_code_o == 6'd0 || ip_code_o == 6'(BYPASS_CODE) ||
                        (ip_code_o >= 6'(BASE_CODE) && ip_code_o < 6'(BASE_CODE + NUM_SRC))));

    // R5
    a_r5_code_holds: assert property (@(posedge clk) disable iff (rst)
        (live_q && !ip_valid_o) |-> $stable(ip_code_o));

    // R2
    a_r2_no_edge_no_event: assert property (@(posedge clk) disable iff (rst)
        ({bypass_i, src_i} == seen_q) |=> !ip_valid_o);

    // R7
    a_r7_fall_clears: assert property (@(posedge clk) disable iff (rst)
        ((|(~{bypass_i, src_i} & seen_q)) && !(|({bypass_i, src_i} & ~seen_q)))
        |=> (ip_valid_o && ip_code_o == 6'd0));
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(
    .NUM_SRC(NUM_SRC), .BASE_CODE(BASE_CODE), .BYPASS_CODE(BYPASS_CODE)
) u_chk (
    .clk(clk), .rst(rst), .src_i(src_i), .bypass_i(bypass_i),
    .ip_code_o(ip_code_o), .ip_valid_o(ip_valid_o)
);

// File: tb/irq_level_ctrl_test.sv
module irq_level_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] src_i = '0;
    logic        bypass_i = 1'b0;
    logic [4:0]  bus_addr_i = '0;
    logic [3:0]  bus_be_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic        bus_wr_i = 1'b0;
    logic [31:0] bus_rdata_o;
    logic [5:0]  ip_code_o;
    logic        ip_valid_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [5:0] exp_code = '0;

    irq_level_ctrl uut (.*);

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_addr_i = a; bus_be_i = be; bus_wdata_i = d; bus_wr_i = 1'b1;
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr_i = a; bus_wr_i = 1'b0;
        @(negedge clk);
        d = bus_rdata_o;
    endtask

    task automatic rd_check(input string req, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic drive_src(input logic [15:0] v);
        @(negedge clk);
        src_i = v;
        @(negedge clk);
    endtask

    function automatic logic [2:0] lvl_of(input int s, input int k);
        return 3'((s * 5 + k) % 8);
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 valid", 32'(ip_valid_o), 0);
        check("R1 code", 32'(ip_code_o), 0);
        rd_check("R1 pend", 5'd0, 32'h0000FFFF);
        rd_check("R1 mask", 5'd4, 0);
        for (int r = 0; r < 4; r++) rd_check("R1 lvl", 5'(16 + 4*r), 0);

        // R3 R4 R5 R2 R7 sweep
        for (int k = 0; k < 8; k++) begin
            for (int m = 0; m < 8; m++) begin
                for (int r = 0; r < 4; r++) begin
                    logic [31:0] w;
                    for (int b = 0; b < 4; b++)
                        w[b*8 +: 8] = {5'b10110, lvl_of(r*4 + b, k)};
                    wr(5'(16 + 4*r), 4'hF, w);
                end
                wr(5'd4, 4'hF, 32'(m));
                for (int s = 0; s < 16; s++) begin
                    bit q;
                    q = lvl_of(s, k) > 3'(m);
                    wr(5'd0, 4'hF, 32'h0000FFFF);
                    drive_src(16'(1) << s);
                    check("R4 valid", 32'(ip_valid_o), 32'(q));
                    if (q) exp_code = 6'(16 + s);
                    check("R5 code", 32'(ip_code_o), 32'(exp_code));
                    @(negedge clk);
                    check("R2 held high one event", 32'(ip_valid_o), 0);
                    check("R5 code holds", 32'(ip_code_o), 32'(exp_code));
                    rd_check("R2 pend bit", 5'd0, 32'h0000FFFF & ~(32'(1) << s));
                    drive_src('0);
                    exp_code = '0;
                    check("R7 fall valid", 32'(ip_valid_o), 1);
                    check("R7 fall code", 32'(ip_code_o), 0);
                end
            end
        end

        // R4 threshold above level range via byte lane 1
        wr(5'd16, 4'hF, 32'h07070707);
        wr(5'd4, 4'h2, 32'h00000100);
        rd_check("R9 mask lane1", 5'd4, 32'h00000107);
        wr(5'd4, 4'h1, 32'h00000000);
        drive_src(16'h0001);
        check("R4 wide mask blocks", 32'(ip_valid_o), 0);
        drive_src('0);

        // R9 all byte-enable patterns
        for (int be = 0; be < 16; be++) begin
            logic [31:0] e;
            wr(5'd20, 4'hF, 32'h11223344);
            wr(5'd20, 4'(be), 32'hAABBCCDD);
            for (int b = 0; b < 4; b++)
                e[b*8 +: 8] = be[b] ? 8'(32'hAABBCCDD >> (8*b)) : 8'(32'h11223344 >> (8*b));
            rd_check("R9 byte lanes", 5'd20, e);
        end

        // R10 unmapped offsets
        wr(5'd4, 4'hF, 32'h00000003);
        wr(5'd8, 4'hF, 32'hFFFFFFFF);
        wr(5'd12, 4'hF, 32'hFFFFFFFF);
        rd_check("R10 off8", 5'd8, 0);
        rd_check("R10 off12", 5'd12, 0);
        rd_check("R10 mask intact", 5'd4, 32'h00000003);
        rd_check("R10 lvl intact", 5'd20, 32'h11223344 ^ 32'h11223344 ^ 32'hAABBCCDD);

        // R8 simultaneous rises
        for (int r = 0; r < 4; r++) wr(5'(16 + 4*r), 4'hF, 32'h07070707);
        wr(5'd4, 4'hF, 0);
        wr(5'd0, 4'hF, 32'h0000FFFF);
        drive_src(16'hA0A0);
        check("R8 lowest", 32'(ip_code_o), 16 + 5);
        rd_check("R8 pend", 5'd0, 32'h0000FFFF & ~32'hA0A0);
        drive_src('0);
        wr(5'd20, 4'h2, 32'h0);
        drive_src(16'hA0A0);
        check("R8 lowest qualifying", 32'(ip_code_o), 16 + 7);
        drive_src('0);

        // R6 bypass
        wr(5'd0, 4'hF, 32'h0000FFFF);
        @(negedge clk);
        bypass_i = 1'b1;
        @(negedge clk);
        check("R6 bypass code", 32'(ip_code_o), 32);
        check("R6 bypass valid", 32'(ip_valid_o), 1);
        rd_check("R6 pend untouched", 5'd0, 32'h0000FFFF);
        @(negedge clk);
        bypass_i = 1'b0;
        @(negedge clk);
        check("R7 bypass fall", 32'(ip_code_o), 0);
        @(negedge clk);
        bypass_i = 1'b1; src_i = 16'h0008;
        @(negedge clk);
        check("R6 precedence", 32'(ip_code_o), 32);
        rd_check("R6 src still pends", 5'd0, 32'h0000FFF7);
        @(negedge clk);
        bypass_i = 1'b0; src_i = '0;

        // R11 write racing an edge
        wr(5'd0, 4'hF, 32'h00000000);
        @(negedge clk);
        bus_addr_i = 5'd0; bus_be_i = 4'hF; bus_wdata_i = 32'h0000FFFF; bus_wr_i = 1'b1;
        src_i = 16'h0004;
        @(negedge clk);
        bus_wr_i = 1'b0;
        rd_check("R11 edge wins", 5'd0, 32'h0000FFFB);
        drive_src('0);

        // R1 reset mid-operation
        wr(5'd4, 4'hF, 32'h5);
        drive_src(16'h0001);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        src_i = '0;
        check("R1 code after reset", 32'(ip_code_o), 0);
        rd_check("R1 pend after reset", 5'd0, 32'h0000FFFF);
        rd_check("R1 mask after reset", 5'd4, 0);
        rd_check("R1 lvl after reset", 5'd16, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule